// File: doc/BRIEF.md
# Remote Terminal Mailbox Address Generator

This block forms the external address that a serial-bus remote terminal places on its memory bus when it stores a received command word, or when it fetches or stores a data word. Every message goes into a fixed 64-word mailbox. The mailbox is chosen by three things: whether the message was broadcast or sent to the terminal's own address, its transfer direction, and its subaddress. The address is built directly from the decoded command fields. No lookup table is involved.

A load pulse captures the fields of a new command and clears the word index. An advance pulse after each completed data word moves the index on by one. Two inputs act on the output in the same cycle, without passing through a register:

- a select between a command-word access and a data-word access;
- the byte select used in 8-bit mode.

Subaddresses 0 and 31 carry mode codes. For these the word index is replaced by the mode code value. A flag marks the two mode-code transmit responses whose data word comes from internal registers rather than from memory.

Top module: `rt_mailbox_addr`

## Requirements
- R1: On the clock edge where `load_i` is high, bit 13 of `addr_o` takes `bcast_i` (1 = broadcast) and bit 12 takes `tx_i` (1 = transmit). Both hold until the next load.
- R2: Bits 11..7 of `addr_o` carry the subaddress captured at the last load.
- R3: Bit 6 of `addr_o` follows `data_sel_i` in the same cycle (1 = data word, 0 = command word).
- R4: For a command access to a message whose subaddress is neither 0 nor 31, bits 5..1 are zero.
- R5: For a command access to a mode-code message (subaddress 0 or 31), bits 5..1 equal the mode code captured at load.
- R6: For a data access to a message that is not a mode code, bits 5..1 equal the word index. A load clears the word index to zero.
- R7: Each `advance_i` pulse without a load raises the word index by one. From 31 the index wraps to 0, and bit 6 does not change.
- R8: For a data access to a mode-code message, bits 5..1 equal the mode code whatever advance pulses have occurred.
- R9: In 8-bit mode (`byte8_i` = 1), bit 0 is 1 for the upper byte (`byte_lo_i` = 0) and 0 for the lower byte (`byte_lo_i` = 1). In 16-bit mode bit 0 is 0.
- R10: `int_reg_o` is 1 only for a data access to a transmit mode-code message whose mode code is 18 or 19. It is 0 in every other case, including receive messages, command accesses, and the same field values on other subaddresses.
- R11: After reset, with `data_sel_i`, `byte8_i` and `byte_lo_i` at 0, `addr_o` is 0 and `int_reg_o` is 0.
- R12: When `load_i` and `advance_i` are high on the same edge, the load takes priority and the word index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Pulse that captures a new command |
| bcast_i | input | 1 | Command was broadcast |
| tx_i | input | 1 | Command is a transmit |
| subaddr_i | input | 5 | Subaddress field of the command |
| field_i | input | 5 | Word count / mode code field of the command |
| advance_i | input | 1 | Pulse after each completed data word |
| data_sel_i | input | 1 | 1 = data access, 0 = command-word access |
| byte8_i | input | 1 | 8-bit transfer mode |
| byte_lo_i | input | 1 | Lower byte of the pair in 8-bit mode |
| addr_o | output | 14 | Mailbox word/byte address |
| int_reg_o | output | 1 | Data word is served from internal registers |

## Verification
Each wrong internal state shows at the ports as follows:

- A wrongly captured field shows on bits 13..7 in the first cycle after the load.
- A counter that fails to clear shows on the first data access after the load.
- A counter that misses an increment or a wrap shows on the next data access after the pulse.
- A mode-code decision that goes the wrong way appears at once, as either the wrong offset source on bits 5..1 or a wrong `int_reg_o`.

The scoreboard compares every cycle. The error is therefore reported in the cycle in which it first reaches the ports.

// File: rtl/rtmb_pkg.sv
package rtmb_pkg;
    parameter int SA_W   = 5;
    parameter int WC_W   = 5;
    localparam int ADDR_W = 2 + SA_W + 1 + WC_W + 1;
    localparam int MC_TX_LAST = 18;
    localparam int MC_TX_BIT  = 19;
endpackage

// File: rtl/rtmb_cmd_latch.sv
module rtmb_cmd_latch #(
    parameter int SA_W = rtmb_pkg::SA_W,
    parameter int WC_W = rtmb_pkg::WC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            bcast_i,
    input  logic            tx_i,
    input  logic [SA_W-1:0] sa_i,
    input  logic [WC_W-1:0] fld_i,
    output logic            bcast_o,
    output logic            tx_o,
    output logic [SA_W-1:0] sa_o,
    output logic [WC_W-1:0] fld_o,
    output logic            mode_o
);
    typedef struct packed {
        logic            bcast;
        logic            tx;
        logic [SA_W-1:0] sa;
        logic [WC_W-1:0] fld;
        logic            mode;
    } cmd_st_t;

    cmd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.bcast = bcast_i;
            st_d.tx    = tx_i;
            st_d.sa    = sa_i;
            st_d.fld   = fld_i;
            st_d.mode  = (sa_i == '0) || (sa_i == '1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bcast_o = st_q.bcast;
    assign tx_o    = st_q.tx;
    assign sa_o    = st_q.sa;
    assign fld_o   = st_q.fld;
    assign mode_o  = st_q.mode;

    // R5: a mode-code message is one whose subaddress is all zeros or all ones
    assert_mode_decode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (mode_o == (($past(sa_i) == '0) || ($past(sa_i) == '1))));

    assert_hold_no_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(sa_o) && $stable(fld_o)));
endmodule

// File: rtl/rtmb_word_ctr.sv
module rtmb_word_ctr #(
    parameter int WC_W = rtmb_pkg::WC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            advance_i,
    output logic [WC_W-1:0] cnt_o
);
    logic [WC_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)         cnt_d = '0;
        else if (advance_i) cnt_d = cnt_q + WC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    assert_load_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_o == '0));

    assert_advance_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && advance_i) |=> (cnt_o == $past(cnt_o) + WC_W'(1)));

    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && advance_i && cnt_o == '1) |=> (cnt_o == '0));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !advance_i) |=> $stable(cnt_o));
endmodule

// File: rtl/rtmb_addr_pack.sv
module rtmb_addr_pack #(
    parameter int SA_W = rtmb_pkg::SA_W,
    parameter int WC_W = rtmb_pkg::WC_W,
    localparam int ADDR_W = 2 + SA_W + 1 + WC_W + 1
) (
    input  logic              bcast_i,
    input  logic              tx_i,
    input  logic [SA_W-1:0]   sa_i,
    input  logic [WC_W-1:0]   fld_i,
    input  logic              mode_i,
    input  logic [WC_W-1:0]   cnt_i,
    input  logic              data_sel_i,
    input  logic              byte8_i,
    input  logic              byte_lo_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              int_reg_o
);
    localparam logic [WC_W-1:0] MC_LAST = WC_W'(rtmb_pkg::MC_TX_LAST);
    localparam logic [WC_W-1:0] MC_BIT  = WC_W'(rtmb_pkg::MC_TX_BIT);

    logic [WC_W-1:0] offs;
    logic            byte_bit;

    always_comb begin
        if (mode_i)          offs = fld_i;
        else if (data_sel_i) offs = cnt_i;
        else                 offs = '0;
        byte_bit  = byte8_i & ~byte_lo_i;
        addr_o    = {bcast_i, tx_i, sa_i, data_sel_i, offs, byte_bit};
        int_reg_o = mode_i & tx_i & data_sel_i & ((fld_i == MC_LAST) | (fld_i == MC_BIT));
    end
endmodule

// File: rtl/rt_mailbox_addr.sv
module rt_mailbox_addr #(
    parameter int SA_W = rtmb_pkg::SA_W,
    parameter int WC_W = rtmb_pkg::WC_W,
    localparam int ADDR_W = 2 + SA_W + 1 + WC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              bcast_i,
    input  logic              tx_i,
    input  logic [SA_W-1:0]   subaddr_i,
    input  logic [WC_W-1:0]   field_i,
    input  logic              advance_i,
    input  logic              data_sel_i,
    input  logic              byte8_i,
    input  logic              byte_lo_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              int_reg_o
);
    localparam int BC_POS = ADDR_W - 1;
    localparam int TX_POS = ADDR_W - 2;
    localparam int DS_POS = WC_W + 1;

    logic            bc_q, tx_q, mode_q;
    logic [SA_W-1:0] sa_q;
    logic [WC_W-1:0] fld_q, cnt_q;

    rtmb_cmd_latch #(.SA_W(SA_W), .WC_W(WC_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .load_i(load_i),
        .bcast_i(bcast_i), .tx_i(tx_i), .sa_i(subaddr_i), .fld_i(field_i),
        .bcast_o(bc_q), .tx_o(tx_q), .sa_o(sa_q), .fld_o(fld_q), .mode_o(mode_q)
    );

    rtmb_word_ctr #(.WC_W(WC_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .advance_i(advance_i),
        .cnt_o(cnt_q)
    );

    rtmb_addr_pack #(.SA_W(SA_W), .WC_W(WC_W)) u_pack (
        .bcast_i(bc_q), .tx_i(tx_q), .sa_i(sa_q), .fld_i(fld_q), .mode_i(mode_q),
        .cnt_i(cnt_q), .data_sel_i(data_sel_i), .byte8_i(byte8_i),
        .byte_lo_i(byte_lo_i), .addr_o(addr_o), .int_reg_o(int_reg_o)
    );

    assert_route_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr_o[BC_POS] == $past(bcast_i) && addr_o[TX_POS] == $past(tx_i)));

    assert_subaddr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr_o[ADDR_W-3 -: SA_W] == $past(subaddr_i)));

    assert_intreg_scope_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int_reg_o |-> (addr_o[DS_POS] && addr_o[TX_POS]));

    assert_word_mode_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !byte8_i |-> !addr_o[0]);
endmodule

// File: tb/sim_rt_mailbox_addr.sv
module sim_rt_mailbox_addr;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_i = 0, bcast_i = 0, tx_i = 0, advance_i = 0;
    logic data_sel_i = 0, byte8_i = 0, byte_lo_i = 0;
    logic [4:0] subaddr_i = 0, field_i = 0;
    logic [13:0] addr_o;
    logic int_reg_o;

    always #2 clk = ~clk;

    rt_mailbox_addr u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .bcast_i(bcast_i), .tx_i(tx_i),
        .subaddr_i(subaddr_i), .field_i(field_i), .advance_i(advance_i),
        .data_sel_i(data_sel_i), .byte8_i(byte8_i), .byte_lo_i(byte_lo_i),
        .addr_o(addr_o), .int_reg_o(int_reg_o)
    );

    typedef struct {
        logic [13:0] addr;
        logic        ir;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic       m_bc = 0, m_tx = 0;
    logic [4:0] m_sa = 0, m_mc = 0, m_cnt = 0;

    function automatic exp_t predict(logic ds, logic b8, logic blo, string tag);
        exp_t e;
        logic mode;
        logic [4:0] off;
        mode = (m_sa == 5'd0) || (m_sa == 5'd31);
        off  = mode ? m_mc : (ds ? m_cnt : 5'd0);
        e.addr = {m_bc, m_tx, m_sa, ds, off, (b8 && !blo)};
        e.ir   = mode && m_tx && ds && (m_mc == 5'd18 || m_mc == 5'd19);
        e.tag  = tag;
        return e;
    endfunction

    task automatic step(input logic ld, input logic adv, input logic bc, input logic tx,
                        input logic [4:0] sa, input logic [4:0] mc, input logic ds,
                        input logic b8, input logic blo, input string tag);
        @(negedge clk);
        #1;
        load_i = ld; advance_i = adv; bcast_i = bc; tx_i = tx;
        subaddr_i = sa; field_i = mc; data_sel_i = ds; byte8_i = b8; byte_lo_i = blo;
        if (ld) begin
            m_bc = bc; m_tx = tx; m_sa = sa; m_mc = mc; m_cnt = 5'd0;
        end else if (adv) begin
            m_cnt = m_cnt + 5'd1;
        end
        sb.push_back(predict(ds, b8, blo, tag));
    endtask

    // hold the last message and change only the access-side inputs
    task automatic look(input logic ds, input logic b8, input logic blo, input string tag);
        step(0, 0, bcast_i, tx_i, subaddr_i, field_i, ds, b8, blo, tag);
    endtask

    task automatic adv_n(input int n);
        for (int i = 0; i < n; i++)
            step(0, 1, bcast_i, tx_i, subaddr_i, field_i, 1, 0, 0, "R7");
    endtask

    // monitor: compares one expected item per cycle
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (addr_o !== e.addr || int_reg_o !== e.ir) begin
                errors++;
                $display("FAIL %s: addr=%h ir=%b expected addr=%h ir=%b",
                         e.tag, addr_o, int_reg_o, e.addr, e.ir);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (addr_o !== 14'd0 || int_reg_o !== 1'b0) begin
            errors++;
            $display("FAIL R11: addr=%h ir=%b expected addr=0000 ir=0", addr_o, int_reg_o);
        end
        rst_n = 1'b1;

        // R4 R1 R2: receive, own address, subaddress 5, command access
        step(1, 0, 0, 0, 5'd5, 5'd3, 0, 0, 0, "R4");
        look(1, 0, 0, "R6");                 // R3 R6: data access, index 0
        adv_n(3);                             // R7: index 1..3
        look(0, 0, 0, "R3");                  // back to command word
        // R1: broadcast transmit on subaddress 12
        step(1, 0, 1, 1, 5'd12, 5'd0, 0, 0, 0, "R1");
        look(1, 0, 0, "R2");
        // R7 wrap: 32 advances come back to 0, bit 6 untouched
        step(1, 0, 0, 0, 5'd1, 5'd10, 1, 0, 0, "R6");
        adv_n(31);
        adv_n(1);
        // R5 R8: mode code on subaddress 0 and 31
        step(1, 0, 0, 0, 5'd0, 5'd17, 0, 0, 0, "R5");
        look(1, 0, 0, "R8");
        step(0, 1, 0, 0, 5'd0, 5'd17, 1, 0, 0, "R8");
        step(0, 1, 0, 0, 5'd0, 5'd17, 1, 0, 0, "R8");
        step(1, 0, 1, 0, 5'd31, 5'd2, 0, 0, 0, "R5");
        // R10: internal-register responses and their near misses
        step(1, 0, 0, 1, 5'd0, 5'd18, 1, 0, 0, "R10");
        look(0, 0, 0, "R10");
        step(1, 0, 0, 1, 5'd31, 5'd19, 1, 0, 0, "R10");
        step(1, 0, 0, 0, 5'd31, 5'd18, 1, 0, 0, "R10");
        step(1, 0, 0, 1, 5'd5, 5'd18, 1, 0, 0, "R10");
        step(1, 0, 0, 1, 5'd0, 5'd20, 1, 0, 0, "R10");
        // R9: byte select
        step(1, 0, 0, 1, 5'd7, 5'd4, 1, 1, 0, "R9");
        look(1, 1, 1, "R9");
        look(1, 0, 1, "R9");
        // R12: load and advance on the same edge
        adv_n(2);
        step(1, 1, 0, 0, 5'd9, 5'd6, 1, 0, 0, "R12");
        look(1, 0, 0, "R12");

        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule